// File: doc/BRIEF.md
# RTC Interrupt Flag and Alarm Unit

This block holds the interrupt status and enable logic of a PC-style real-time clock. It takes three event sources: a periodic tick from a divider tap, a once-per-second update-ended pulse, and an alarm match. The alarm match compares the current hours, minutes and seconds bytes against three alarm bytes. Each event sets its own status flag whatever its enable is. A combined interrupt flag is raised when any flag is set and its enable is also set. While that combined flag is high, the active-low interrupt output is driven low.

A small register bus reaches two locations. Address 0 is a read/write control register that holds the enables and the mode bits. Address 1 is a read-only status register, and any read of it clears every flag. Time keeping, the divider chain, rate selection and BCD/binary arithmetic are done outside this block. The block only stores the data-mode and 24/12-hour bits for that logic to use.

Top module: `rtc_irq_unit`

## Requirements
- R1: Status register (address 1) layout: bit 7 combined interrupt flag, bit 6 periodic flag, bit 5 alarm flag, bit 4 update-ended flag. Bits 3..0 always read 0.
- R2: A periodic tick sets the periodic flag, and an update-ended pulse sets the update-ended flag, regardless of the enable bits. With the enables clear, irq_n stays high.
- R3: The combined flag is 1, and irq_n is 0, exactly when some flag and its enable are both 1. Both become visible in the cycle after the clock edge that samples the event.
- R4: A status read returns the current flags and clears all of them at that clock edge. A following read returns 0x00 and irq_n goes high.
- R5: If an event arrives in the same cycle as a status read, the read returns the old value and the new event's flag stays set afterwards.
- R6: Reset clears all flags and the periodic, alarm and update enables, and drives irq_n high. Reset leaves the data-mode and 24/12-hour bits unchanged.
- R7: A control write that takes the set bit from 0 to 1 also clears the update enable, whatever is written to bit 4. A write while the set bit is already 1 keeps the written bit 4.
- R8: On an update-ended pulse, the alarm flag is set if every time byte equals its alarm byte. An alarm byte whose top two bits are 11 matches any value.
- R9: The alarm flag is not set when any non-wildcard byte differs, or when no update-ended pulse occurs. An alarm byte with top bits 10 is an ordinary value.
- R10: Control register (address 0) layout: bit 7 set, bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 2 data mode (1 = binary), bit 1 24-hour mode. Bits 3 and 0 always read 0.
- R11: Flag events never change the periodic or alarm enables. Only a control write or reset changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| periodic_tick | input | 1 | Periodic event pulse |
| update_done | input | 1 | Update-ended pulse, once per second |
| cur_time | input | 24 | Current {hours, minutes, seconds} |
| alm_time | input | 24 | Alarm {hours, minutes, seconds} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Flags and enables are registers, so an event or a control write is sampled at one clock edge and shows up on irq_n and on the read path in the following cycle. Read data is combinational from the stored state and is valid during the access cycle itself. The clear-on-read takes effect at the edge that ends that access. The bench drives inputs at falling edges, holds each event for one cycle, and samples irq_n at the next falling edge. It captures read data 1 ns after raising the strobe, which is well before the edge that applies the clear.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned TIME_BYTES = 3;

  // register addresses
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // status bit positions
  localparam int unsigned ST_IRQ = 7;
  localparam int unsigned ST_PER = 6;
  localparam int unsigned ST_ALM = 5;
  localparam int unsigned ST_UPD = 4;

  // control bit positions
  localparam int unsigned CT_SET  = 7;
  localparam int unsigned CT_PEN  = 6;
  localparam int unsigned CT_AEN  = 5;
  localparam int unsigned CT_UEN  = 4;
  localparam int unsigned CT_BIN  = 2;
  localparam int unsigned CT_H24  = 1;

  typedef struct packed {
    logic set;
    logic pen;
    logic aen;
    logic uen;
    logic bin;
    logic h24;
  } ctrl_t;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } flags_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned FIELDS = 3,
  parameter int unsigned FW     = 8
) (
  input  logic [FIELDS*FW-1:0] cur,
  input  logic [FIELDS*FW-1:0] alm,
  output logic                 match
);
  logic [FIELDS-1:0] hit;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    logic [FW-1:0] c_b;
    logic [FW-1:0] a_b;
    logic          wild;
    assign c_b    = cur[i*FW +: FW];
    assign a_b    = alm[i*FW +: FW];
    assign wild   = (a_b[FW-1 -: 2] == 2'b11);
    assign hit[i] = wild | (c_b == a_b);
  end

  assign match = &hit;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl
);
  logic set_q, pen_q, aen_q, uen_q;
  logic set_d, pen_d, aen_d, uen_d;
  logic bin_q, h24_q;
  logic set_rise;

  assign set_rise = wdata[CT_SET] & ~set_q;

  always_comb begin
    set_d = set_q;
    pen_d = pen_q;
    aen_d = aen_q;
    uen_d = uen_q;
    if (wr_en) begin
      set_d = wdata[CT_SET];
      pen_d = wdata[CT_PEN];
      aen_d = wdata[CT_AEN];
      uen_d = wdata[CT_UEN] & ~set_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= 1'b0;
      pen_q <= 1'b0;
      aen_q <= 1'b0;
      uen_q <= 1'b0;
    end else begin
      set_q <= set_d;
      pen_q <= pen_d;
      aen_q <= aen_d;
      uen_q <= uen_d;
    end
  end

  // mode bits keep their value through reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      bin_q <= wdata[CT_BIN];
      h24_q <= wdata[CT_H24];
    end
  end

  assign ctrl = '{set: set_q, pen: pen_q, aen: aen_q, uen: uen_q,
                  bin: bin_q, h24: h24_q};
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  flags_t evt,
  output flags_t flags
);
  flags_t flags_q, flags_d;

  // a coincident event wins over the clear
  always_comb begin
    flags_d = clr ? '0 : flags_q;
    flags_d = flags_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW     = BYTE_W,
  parameter int unsigned NBYTES = TIME_BYTES,
  localparam int unsigned TW    = DW * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          periodic_tick,
  input  logic          update_done,
  input  logic [TW-1:0] cur_time,
  input  logic [TW-1:0] alm_time,
  output logic          irq_n
);
  ctrl_t  ctrl;
  flags_t flags;
  flags_t evt;
  logic   wr_ctrl, rd_stat;
  logic   alm_match;
  logic   irq_any;

  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == ADDR_CTRL);
  assign rd_stat = bus_sel & ~bus_wr & (bus_addr == ADDR_STAT);

  rtc_alarm_cmp #(.FIELDS(NBYTES), .FW(DW)) u_cmp (
    .cur   (cur_time),
    .alm   (alm_time),
    .match (alm_match)
  );

  assign evt.per = periodic_tick;
  assign evt.upd = update_done;
  assign evt.alm = update_done & alm_match;

  rtc_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ctrl),
    .wdata (bus_wdata),
    .ctrl  (ctrl)
  );

  rtc_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rd_stat),
    .evt   (evt),
    .flags (flags)
  );

  assign irq_any = (flags.per & ctrl.pen) | (flags.alm & ctrl.aen) |
                   (flags.upd & ctrl.uen);
  assign irq_n   = ~irq_any;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_STAT) begin
      bus_rdata[ST_IRQ] = irq_any;
      bus_rdata[ST_PER] = flags.per;
      bus_rdata[ST_ALM] = flags.alm;
      bus_rdata[ST_UPD] = flags.upd;
    end else begin
      bus_rdata[CT_SET] = ctrl.set;
      bus_rdata[CT_PEN] = ctrl.pen;
      bus_rdata[CT_AEN] = ctrl.aen;
      bus_rdata[CT_UEN] = ctrl.uen;
      bus_rdata[CT_BIN] = ctrl.bin;
      bus_rdata[CT_H24] = ctrl.h24;
    end
  end
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       periodic_tick,
  input logic       update_done,
  input logic       irq_n,
  input logic       f_per,
  input logic       f_alm,
  input logic       f_upd,
  input logic       c_set,
  input logic       c_pen,
  input logic       c_aen,
  input logic       c_uen
);
  logic rd_st, rd_ct, wr_ct;
  assign rd_st = bus_sel && !bus_wr && bus_addr;
  assign rd_ct = bus_sel && !bus_wr && !bus_addr;
  assign wr_ct = bus_sel && bus_wr && !bus_addr;

  assert_stat_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |-> (bus_rdata[3:0] == 4'h0));

  assert_tick_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_tick |=> f_per);

  assert_enabled_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_per && c_pen) || (f_upd && c_uen)) |-> !irq_n);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !periodic_tick && !update_done) |=> (!f_per && !f_alm && !f_upd && irq_n));

  assert_keep_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && update_done) |=> f_upd);

  assert_set_rise_uie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ct && bus_wdata[7] && !c_set) |=> !c_uen);

  assert_ctrl_rsv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ct |-> (bus_rdata[3] == 1'b0 && bus_rdata[0] == 1'b0));

  assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ct |=> ($stable(c_pen) && $stable(c_aen)));
endmodule

bind rtc_irq_unit rtc_irq_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .periodic_tick (periodic_tick),
  .update_done   (update_done),
  .irq_n         (irq_n),
  .f_per         (flags.per),
  .f_alm         (flags.alm),
  .f_upd         (flags.upd),
  .c_set         (ctrl.set),
  .c_pen         (ctrl.pen),
  .c_aen         (ctrl.aen),
  .c_uen         (ctrl.uen)
);

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        periodic_tick, update_done;
  logic [23:0] cur_time, alm_time;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_unit u_rtc_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periodic_tick(periodic_tick), .update_done(update_done),
    .cur_time(cur_time), .alm_time(alm_time), .irq_n(irq_n)
  );

  // {ctrl[8], tick, upd, cur[24], alm[24], exp_status[8], exp_irq_n}
  localparam logic [66:0] VECS [NVEC] = '{
    {8'h00, 1'b1, 1'b0, 24'h123456, 24'h000000, 8'h40, 1'b1}, // R2
    {8'h40, 1'b1, 1'b0, 24'h123456, 24'h000000, 8'hC0, 1'b0}, // R3
    {8'h20, 1'b0, 1'b1, 24'h123456, 24'h123456, 8'hB0, 1'b0}, // R8
    {8'h10, 1'b0, 1'b1, 24'h123456, 24'h123457, 8'h90, 1'b0}, // R9
    {8'h00, 1'b0, 1'b1, 24'h123456, 24'hC0FFC5, 8'h30, 1'b1}, // R8 wildcard
    {8'h20, 1'b0, 1'b0, 24'h123456, 24'h123456, 8'h00, 1'b1}, // R9 no pulse
    {8'h60, 1'b1, 1'b1, 24'h235959, 24'h235959, 8'hF0, 1'b0}, // R3
    {8'h16, 1'b0, 1'b1, 24'h123456, 24'h803456, 8'h90, 1'b0}  // R9 top bits 10
  };

  task automatic check8(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check1(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic events(logic t, logic u);
    @(negedge clk);
    periodic_tick = t; update_done = u;
    @(negedge clk);
    periodic_tick = 1'b0; update_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [66:0] v;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    periodic_tick = 1'b0; update_done = 1'b0;
    cur_time = '0; alm_time = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    check1("R6 irq_n after reset", irq_n, 1'b1);
    bus_read(1'b1, rd);
    check8("R6 status after reset", rd, 8'h00);
    bus_read(1'b0, rd);
    check8("R6 ctrl enables after reset", rd & 8'hF9, 8'h00);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      bus_read(1'b1, rd);              // clear leftover flags
      bus_write(1'b0, v[66:59]);
      bus_read(1'b0, rd);
      check8("R10 ctrl readback", rd, v[66:59] & 8'hF6);
      cur_time = v[56:33];
      alm_time = v[32:9];
      events(v[58], v[57]);
      check1("R3 irq_n vector", irq_n, v[0]);
      bus_read(1'b1, rd);
      check8("R1/R2/R8/R9 status vector", rd, v[8:1]);
    end

    // R4: read clears, second read empty, irq released
    bus_write(1'b0, 8'h40);
    events(1'b1, 1'b0);
    check1("R3 irq low", irq_n, 1'b0);
    bus_read(1'b1, rd);
    check8("R4 first read", rd, 8'hC0);
    check1("R4 irq_n released", irq_n, 1'b1);
    bus_read(1'b1, rd);
    check8("R4 second read", rd, 8'h00);

    // R5: event coincident with read
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1; periodic_tick = 1'b1;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; periodic_tick = 1'b0;
    check8("R5 read returns old value", rd, 8'h00);
    bus_read(1'b1, rd);
    check8("R5 event kept", rd, 8'hC0);

    // R11: enables unchanged by events
    bus_write(1'b0, 8'h60);
    cur_time = 24'h010203; alm_time = 24'h010203;
    events(1'b1, 1'b1);
    bus_read(1'b0, rd);
    check8("R11 enables held", rd & 8'hF0, 8'h60);

    // R7: set rising clears update enable
    bus_write(1'b0, 8'h10);
    bus_write(1'b0, 8'h90);
    bus_read(1'b0, rd);
    check8("R7 set rise clears uie", rd & 8'hF0, 8'h80);
    bus_write(1'b0, 8'h90);
    bus_read(1'b0, rd);
    check8("R7 set held keeps uie", rd & 8'hF0, 8'h90);

    // R6: reset clears enables and flags, keeps mode bits
    bus_write(1'b0, 8'h76);
    events(1'b1, 1'b1);
    check1("R6 irq before reset", irq_n, 1'b0);
    do_reset();
    check1("R6 irq_n cleared", irq_n, 1'b1);
    bus_read(1'b0, rd);
    check8("R6 ctrl after reset", rd, 8'h06);
    bus_read(1'b1, rd);
    check8("R6 flags after reset", rd, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule